// File: doc/BRIEF.md
# Control Register Read-Modify-Write Unit

This block holds a small, parameterised bank of control and status registers. It carries out the six register-access operations as single-step read-modify-write actions. Each request selects a register by a 12-bit address and gives a 3-bit operation code. It also supplies a 5-bit source field, which is either the index of the source register or an unsigned immediate, along with the source register value and a flag that says whether the destination is register 0. In the request cycle the unit returns the old register contents, zero-extended to the datapath width. At the next rising clock edge it commits the modified value.

The unit also reports side effects. A read strobe marks a request that counts as a read of the register. A write strobe marks a request that changes the register. An illegal flag marks a request that touches no state, either because the address is unknown or because the operation code is not defined. The register addresses, reset values and per-bit writable masks are parameters. Bits outside a register's mask keep their reset value.

Top module: `csr_rmw_unit`

## Requirements
- R1: Operation codes 3'b001 (register source) and 3'b101 (immediate source) replace the register with the source value. In the same cycle, rd_data carries the old contents whenever a read happens.
- R2: Codes 3'b010 and 3'b110 OR the source into the register.
- R3: Codes 3'b011 and 3'b111 AND the register with the inverted source.
- R4: Immediate codes (bit 2 of the code set) take the 5-bit src_field, zero-extended, as the source. rs1_data is ignored for these codes.
- R5: For both replace codes with rd_is_zero high: read_strobe stays low, rd_data is 0, and the write still takes place.
- R6: For the set and clear codes, read_strobe is high and rd_data holds the old value on every legal request, whatever the value of rd_is_zero.
- R7: For the set and clear codes with src_field equal to 0, write_strobe stays low and the register keeps its value.
- R8: A request to an address outside the bank raises illegal. It leaves both strobes low and rd_data 0, and changes no register. With req_valid low, all outputs are 0.
- R9: Operation codes 3'b000 and 3'b100 raise illegal and change no register.
- R10: After reset each register holds its parameter reset value. Bits outside its writable mask never leave that value.
- R11: rd_data bits above the register width read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| csr_addr | input | 12 | Register address |
| op_code | input | 3 | Operation code |
| src_field | input | 5 | Source register index or unsigned immediate |
| rs1_data | input | XLEN | Source register value |
| rd_is_zero | input | 1 | Destination is register 0 |
| rd_data | output | XLEN | Old register value, zero-extended |
| read_strobe | output | 1 | Request counts as a register read |
| write_strobe | output | 1 | Request updates the register |
| illegal | output | 1 | Unknown address or operation code |

## Verification
The bench builds the unit with five registers that are 20 bits wide on a 32-bit datapath. With this build, R11 becomes observable: the upper 12 bits of rd_data must read zero, and the upper bits of rs1_data must be dropped. One register is given a partial writable mask and a non-zero reset value, which lets replace and clear operations show that the read-only bits stay fixed (R10). A second non-zero reset value lets a reset issued mid-run be seen at the port.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

   localparam int ADDR_W  = 12;
   localparam int FIELD_W = 5;

   typedef enum logic [1:0] {
      K_BAD   = 2'b00,
      K_WRITE = 2'b01,
      K_SET   = 2'b10,
      K_CLEAR = 2'b11
   } csr_kind_e;

   typedef struct packed {
      csr_kind_e kind;
      logic      use_imm;
   } csr_dec_t;

endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
   import csr_rmw_pkg::*;
(
   input  logic [2:0] op_code,
   output csr_dec_t   dec
);
   always_comb begin
      dec.use_imm = op_code[2];
      unique case (op_code[1:0])
         2'b01:   dec.kind = K_WRITE;
         2'b10:   dec.kind = K_SET;
         2'b11:   dec.kind = K_CLEAR;
         default: dec.kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/csr_src_mux.sv
module csr_src_mux
   import csr_rmw_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int CSR_W = 32
) (
   input  logic               use_imm,
   input  logic [FIELD_W-1:0] src_field,
   input  logic [XLEN-1:0]    rs1_data,
   output logic [CSR_W-1:0]   operand
);
   localparam int PAD_W = CSR_W - FIELD_W;

   logic [CSR_W-1:0] imm_ext;
   assign imm_ext = {{PAD_W{1'b0}}, src_field};
   assign operand = use_imm ? imm_ext : rs1_data[CSR_W-1:0];

   always_comb begin
      if (use_imm) a_r4_imm_zero_ext : assert (operand[CSR_W-1:FIELD_W] == '0);
   end
endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
   import csr_rmw_pkg::*;
#(
   parameter int                          NUM_CSR   = 4,
   parameter int                          CSR_W     = 32,
   parameter logic [NUM_CSR*ADDR_W-1:0]   CSR_ADDRS = '0,
   parameter logic [NUM_CSR*CSR_W-1:0]    CSR_RESET = '0,
   parameter logic [NUM_CSR*CSR_W-1:0]    CSR_MASK  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [CSR_W-1:0]  wdata,
   output logic [CSR_W-1:0]  rdata,
   output logic              hit_any
);
   logic [NUM_CSR-1:0]   hit;
   logic [CSR_W-1:0]     q     [NUM_CSR];
   logic [CSR_W-1:0]     gated [NUM_CSR];

   for (genvar i = 0; i < NUM_CSR; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = CSR_ADDRS[i*ADDR_W +: ADDR_W];
      localparam logic [CSR_W-1:0]  MY_RST  = CSR_RESET[i*CSR_W +: CSR_W];
      localparam logic [CSR_W-1:0]  MY_MASK = CSR_MASK[i*CSR_W +: CSR_W];

      assign hit[i]   = (addr == MY_ADDR);
      assign gated[i] = hit[i] ? q[i] : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            q[i] <= MY_RST;
         else if (we && hit[i]) q[i] <= (wdata & MY_MASK) | (MY_RST & ~MY_MASK);
      end

      a_r10_fixed_bits : assert property (@(posedge clk) disable iff (!rst_n)
         (q[i] & ~MY_MASK) == (MY_RST & ~MY_MASK));
      a_r7_hold_unless_written : assert property (@(posedge clk) disable iff (!rst_n)
         !(we && hit[i]) |=> $stable(q[i]));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CSR; i++) rdata = rdata | gated[i];
   end
   assign hit_any = |hit;

   a_r8_single_hit : assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
   import csr_rmw_pkg::*;
#(
   parameter int                          XLEN      = 32,
   parameter int                          CSR_W     = 32,
   parameter int                          NUM_CSR   = 4,
   parameter logic [NUM_CSR*ADDR_W-1:0]   CSR_ADDRS = {12'h343, 12'h342, 12'h341, 12'h340},
   parameter logic [NUM_CSR*CSR_W-1:0]    CSR_RESET = '0,
   parameter logic [NUM_CSR*CSR_W-1:0]    CSR_MASK  = {(NUM_CSR*CSR_W){1'b1}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [11:0]       csr_addr,
   input  logic [2:0]        op_code,
   input  logic [4:0]        src_field,
   input  logic [XLEN-1:0]   rs1_data,
   input  logic              rd_is_zero,
   output logic [XLEN-1:0]   rd_data,
   output logic              read_strobe,
   output logic              write_strobe,
   output logic              illegal
);
   localparam int EXT_W = XLEN - CSR_W;

   if (NUM_CSR < 4)          begin : g_chk_num  $error("NUM_CSR must be at least 4"); end
   if (CSR_W < 8)            begin : g_chk_w    $error("CSR_W must be at least 8"); end
   if (CSR_W > XLEN)         begin : g_chk_x    $error("CSR_W must not exceed XLEN"); end

   csr_dec_t         dec;
   logic [CSR_W-1:0] operand;
   logic [CSR_W-1:0] old_val;
   logic [CSR_W-1:0] new_val;
   logic             hit_any;
   logic             legal;
   logic             is_write;
   logic             src_nonzero;

   csr_op_decode u_dec (
      .op_code (op_code),
      .dec     (dec)
   );

   csr_src_mux #(.XLEN(XLEN), .CSR_W(CSR_W)) u_src (
      .use_imm   (dec.use_imm),
      .src_field (src_field),
      .rs1_data  (rs1_data),
      .operand   (operand)
   );

   csr_reg_bank #(
      .NUM_CSR   (NUM_CSR),
      .CSR_W     (CSR_W),
      .CSR_ADDRS (CSR_ADDRS),
      .CSR_RESET (CSR_RESET),
      .CSR_MASK  (CSR_MASK)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (csr_addr),
      .we      (write_strobe),
      .wdata   (new_val),
      .rdata   (old_val),
      .hit_any (hit_any)
   );

   assign legal       = req_valid && hit_any && (dec.kind != K_BAD);
   assign illegal     = req_valid && !(hit_any && (dec.kind != K_BAD));
   assign is_write    = (dec.kind == K_WRITE);
   assign src_nonzero = |src_field;

   assign read_strobe  = legal && !(is_write && rd_is_zero);
   assign write_strobe = legal && (is_write || src_nonzero);

   always_comb begin
      unique case (dec.kind)
         K_WRITE: new_val = operand;
         K_SET:   new_val = old_val | operand;
         K_CLEAR: new_val = old_val & ~operand;
         default: new_val = old_val;
      endcase
   end

   if (EXT_W > 0) begin : g_ext
      assign rd_data = read_strobe ? {{EXT_W{1'b0}}, old_val} : '0;
      a_r11_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[XLEN-1:CSR_W] == '0);
   end else begin : g_noext
      assign rd_data = read_strobe ? old_val : '0;
   end

   a_r8_illegal_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!write_strobe && !read_strobe && rd_data == '0));
   a_r5_write_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !illegal && op_code[1:0] == 2'b01 && rd_is_zero) |-> (!read_strobe && write_strobe));
   a_r6_setclr_reads : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !illegal && op_code[1]) |-> read_strobe);
   a_r7_zero_src_no_write : assert property (@(posedge clk) disable iff (!rst_n)
      (op_code[1] && src_field == '0) |-> !write_strobe);
   a_r9_bad_code : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op_code[1:0] == 2'b00) |-> illegal);
endmodule

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb;
   localparam int XLEN = 32;
   localparam int CW   = 20;
   localparam int NCSR = 5;
   localparam logic [NCSR*12-1:0] ADDRS = {12'h7C4, 12'h7C3, 12'h342, 12'h341, 12'h300};
   localparam logic [NCSR*CW-1:0] RSTV  = {20'h0, 20'h0, 20'h000A5, 20'h0, 20'h00012};
   localparam logic [NCSR*CW-1:0] MASKS = {20'hFFFFF, 20'hFFFFF, 20'h0FF00, 20'hFFFFF, 20'hFFFFF};

   localparam logic [2:0] OP_RW = 3'b001, OP_RS = 3'b010, OP_RC = 3'b011;
   localparam logic [2:0] OP_RWI = 3'b101, OP_RSI = 3'b110, OP_RCI = 3'b111;

   logic            clk = 0, rst_n = 0, req_valid = 0, rd_is_zero = 0;
   logic [11:0]     csr_addr = '0;
   logic [2:0]      op_code = '0;
   logic [4:0]      src_field = '0;
   logic [XLEN-1:0] rs1_data = '0;
   logic [XLEN-1:0] rd_data;
   logic            read_strobe, write_strobe, illegal;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   csr_rmw_unit #(.XLEN(XLEN), .CSR_W(CW), .NUM_CSR(NCSR),
                  .CSR_ADDRS(ADDRS), .CSR_RESET(RSTV), .CSR_MASK(MASKS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .csr_addr(csr_addr),
      .op_code(op_code), .src_field(src_field), .rs1_data(rs1_data),
      .rd_is_zero(rd_is_zero), .rd_data(rd_data), .read_strobe(read_strobe),
      .write_strobe(write_strobe), .illegal(illegal));

   typedef struct packed {
      logic [11:0] a;   logic [2:0] f;   logic [4:0] fld;  logic [31:0] rs;
      logic        rdz; logic [31:0] erd; logic erfx; logic ewfx; logic eill;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{12'h300, OP_RS,  5'd0,  32'h0,        1'b0, 32'h00012, 1'b1, 1'b0, 1'b0, 8'd10}, // R10
      '{12'h341, OP_RW,  5'd5,  32'h12345678, 1'b0, 32'h0,     1'b1, 1'b1, 1'b0, 8'd1},  // R1
      '{12'h341, OP_RS,  5'd6,  32'hFFF00081, 1'b0, 32'h45678, 1'b1, 1'b1, 1'b0, 8'd2},  // R2
      '{12'h341, OP_RC,  5'd7,  32'h00000678, 1'b0, 32'h456F9, 1'b1, 1'b1, 1'b0, 8'd3},  // R3
      '{12'h341, OP_RS,  5'd0,  32'hFFFFFFFF, 1'b0, 32'h45081, 1'b1, 1'b0, 1'b0, 8'd7},  // R7
      '{12'h341, OP_RSI, 5'd0,  32'hFFFFFFFF, 1'b0, 32'h45081, 1'b1, 1'b0, 1'b0, 8'd7},  // R7
      '{12'h341, OP_RWI, 5'h1F, 32'hABCDE000, 1'b1, 32'h0,     1'b0, 1'b1, 1'b0, 8'd5},  // R5
      '{12'h341, OP_RCI, 5'h03, 32'hFFFFFFFF, 1'b1, 32'h0001F, 1'b1, 1'b1, 1'b0, 8'd6},  // R6 R4
      '{12'h341, OP_RSI, 5'h10, 32'h0,        1'b0, 32'h0001C, 1'b1, 1'b1, 1'b0, 8'd4},  // R4
      '{12'h341, OP_RW,  5'd3,  32'h0,        1'b1, 32'h0,     1'b0, 1'b1, 1'b0, 8'd5},  // R5
      '{12'h341, OP_RS,  5'd0,  32'h0,        1'b0, 32'h0,     1'b1, 1'b0, 1'b0, 8'd5},  // R5 readback
      '{12'h555, OP_RW,  5'd3,  32'h1,        1'b0, 32'h0,     1'b0, 1'b0, 1'b1, 8'd8},  // R8
      '{12'h342, OP_RS,  5'd0,  32'h0,        1'b0, 32'h000A5, 1'b1, 1'b0, 1'b0, 8'd10}, // R10
      '{12'h342, OP_RW,  5'd4,  32'hFFFFFFFF, 1'b0, 32'h000A5, 1'b1, 1'b1, 1'b0, 8'd10}, // R10
      '{12'h342, OP_RC,  5'd4,  32'hFFFFFFFF, 1'b0, 32'h0FFA5, 1'b1, 1'b1, 1'b0, 8'd10}, // R10
      '{12'h7C4, OP_RS,  5'd9,  32'hFFFFFFFF, 1'b0, 32'h0,     1'b1, 1'b1, 1'b0, 8'd11}, // R11
      '{12'h7C4, OP_RC,  5'd0,  32'h0,        1'b0, 32'h000FFFFF, 1'b1, 1'b0, 1'b0, 8'd11}, // R11
      '{12'h300, 3'b000, 5'd3,  32'h1,        1'b0, 32'h0,     1'b0, 1'b0, 1'b1, 8'd9},  // R9
      '{12'h300, 3'b100, 5'd3,  32'h1,        1'b0, 32'h0,     1'b0, 1'b0, 1'b1, 8'd9},  // R9
      '{12'h300, OP_RS,  5'd0,  32'h0,        1'b0, 32'h00012, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 unchanged
      '{12'h7C3, OP_RS,  5'd0,  32'h0,        1'b0, 32'h0,     1'b1, 1'b0, 1'b0, 8'd8}   // R8 unchanged
   };

   task automatic check(input bit ok, input int req, input logic [34:0] act, input logic [34:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d actual={rd,rfx,wfx,ill}=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [11:0] a, input logic [2:0] f, input logic [4:0] fld,
                        input logic [31:0] rs, input logic rdz,
                        input logic [31:0] erd, input logic erfx, input logic ewfx,
                        input logic eill, input int req);
      logic [34:0] act, exp;
      @(negedge clk);
      req_valid = 1; csr_addr = a; op_code = f; src_field = fld; rs1_data = rs; rd_is_zero = rdz;
      #2;
      act = {rd_data, read_strobe, write_strobe, illegal};
      exp = {erd, erfx, ewfx, eill};
      check(act == exp, req, act, exp);
      @(posedge clk);
      #1 req_valid = 0;
   endtask

   initial begin
      logic [34:0] act;
      #3;
      act = {rd_data, read_strobe, write_strobe, illegal};
      check(act == '0, 8, act, '0);   // R8: idle outputs during reset
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      act = {rd_data, read_strobe, write_strobe, illegal};
      check(act == '0, 8, act, '0);   // R8: idle after reset

      for (int k = 0; k < NV; k++)
         apply(VECS[k].a, VECS[k].f, VECS[k].fld, VECS[k].rs, VECS[k].rdz,
               VECS[k].erd, VECS[k].erfx, VECS[k].ewfx, VECS[k].eill, int'(VECS[k].req));

      // R1: immediate replace returns old value and lands
      apply(12'h7C3, OP_RWI, 5'h0A, 32'hFFFFFFFF, 1'b0, 32'h0,  1'b1, 1'b1, 1'b0, 1);
      apply(12'h7C3, OP_RSI, 5'h00, 32'h0,        1'b0, 32'hA,  1'b1, 1'b0, 1'b0, 1);
      // R10: reset mid-run restores reset value
      apply(12'h300, OP_RW,  5'd2,  32'h777,      1'b0, 32'h12, 1'b1, 1'b1, 1'b0, 10);
      apply(12'h300, OP_RS,  5'd0,  32'h0,        1'b0, 32'h777,1'b1, 1'b0, 1'b0, 10);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      apply(12'h300, OP_RS,  5'd0,  32'h0,        1'b0, 32'h12, 1'b1, 1'b0, 1'b0, 10);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule